// File: doc/BRIEF.md
# Feistel Block Cipher Round Engine

This block encrypts or decrypts one 64-bit block with a sixteen-round Feistel network. The key-dependent material lives inside the block: an 18-word array of 32-bit round keys and four 256-word tables of 32-bit words. A host fills both through a simple write port before use. Key expansion and any fixed start-up contents are handled outside the block.

A block enters on a valid/ready handshake together with a direction bit. The engine spends two clock cycles per round. In the first cycle it mixes a round key into the left half and starts the four table reads. In the second cycle the registered table words are combined into the round function, and the halves are updated and swapped. After the last round the final swap is cancelled, the two whitening keys are applied, and the result is held on a valid/ready output until the host takes it. Decryption uses the same datapath with the round keys taken in reverse order.

Top module: `fc_engine`

## Requirements
- R1: The input block is split as left = bits 63:32 and right = bits 31:0. The output uses the same packing. For encryption, each of the 16 rounds applies, in order: left ^= K[r], then right ^= F(left), then the halves are swapped (r = 0..15, 0-based keys). After round 16 the swap is undone, then right ^= K[16] and left ^= K[17].
- R2: The round function on x is F(x) = ((T1[x[31:24]] + T2[x[23:16]]) ^ T3[x[15:8]]) + T4[x[7:0]], with additions modulo 2^32.
- R3: With in_decrypt = 1 the same procedure runs with the round keys K[17] down to K[2], and the whitening is right ^= K[1], left ^= K[0]. Decrypting an encryption result returns the original block.
- R4: in_ready is 1 only while no block is in flight. A block is accepted on a clock edge where in_valid and in_ready are both 1, and in_ready is 0 from the next cycle until the result has been taken.
- R5: out_valid stays 1 and out_block stays unchanged until a clock edge with out_ready = 1. At that edge the result is taken, and the engine is idle in the next cycle.
- R6: out_valid rises exactly 32 clock cycles after the edge that accepts a block.
- R7: A host write with hw_en = 1 while idle stores hw_data as follows. hw_sel = 0 writes round key K[hw_idx] for hw_idx 0..17. hw_sel = 1, 2, 3 or 4 writes entry hw_idx of table T1, T2, T3 or T4. The write affects blocks accepted on later edges.
- R8: Host writes are refused while a block is in flight or a result is waiting. The key array and the tables keep their contents.
- R9: Host writes with hw_sel of 5 to 7, or with hw_sel = 0 and hw_idx of 18 or more, change nothing.
- R10: After reset, in_ready = 1, out_valid = 0, and all round keys are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Engine idle, can accept a block |
| in_block | input | 64 | Input block: left half in 63:32, right half in 31:0 |
| in_decrypt | input | 1 | 1 = decrypt, 0 = encrypt; sampled with the block |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Host takes the result |
| out_block | output | 64 | Result block, same packing as the input |
| hw_en | input | 1 | Host write strobe |
| hw_sel | input | 3 | Write target: 0 = round keys, 1 to 4 = tables T1 to T4 |
| hw_idx | input | 8 | Entry index inside the target |
| hw_data | input | 32 | Word to store |

## Verification
Several block patterns are run through tables filled with pseudo-random words: all zeros, all ones, an alternating bit pattern, and a counting byte pattern. The all-zero and all-ones blocks show whether the key mixing and the whitening are right when the data carries no structure of its own. The irregular patterns send different bytes into each table, so any swapped byte lane, mixed-up table or wrong add/xor order gives a different result. Round trips through decryption separate a correct key reversal from an encryption that only looks right. Writes made during a run, writes with an invalid target, and a write that changes one table entry between runs show which writes should reach the storage and which should be refused.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int HALF_W    = 32;
  localparam int BLK_W     = 2 * HALF_W;
  localparam int ROUNDS    = 16;
  localparam int NKEYS     = ROUNDS + 2;
  localparam int KAW       = $clog2(NKEYS);
  localparam int NTAB      = 4;
  localparam int TAB_AW    = 8;
  localparam int TAB_DEPTH = 1 << TAB_AW;
  localparam int SEL_W     = 3;
  localparam int RND_W     = $clog2(ROUNDS);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_MIX, ST_DONE} fc_state_t;

  // round function combine: add, xor, add (mod 2^32)
  function automatic logic [HALF_W-1:0] f_mix(input logic [HALF_W-1:0] s1,
                                               input logic [HALF_W-1:0] s2,
                                               input logic [HALF_W-1:0] s3,
                                               input logic [HALF_W-1:0] s4);
    return ((s1 + s2) ^ s3) + s4;
  endfunction

  // key used by round rnd; decryption walks the array backwards
  function automatic logic [KAW-1:0] key_index(input logic [RND_W-1:0] rnd,
                                               input logic dec);
    if (dec) return KAW'(NKEYS - 1 - int'(rnd));
    return KAW'(rnd);
  endfunction
endpackage

// File: rtl/fc_subkeys.sv
module fc_subkeys
  import fc_pkg::*;
#(
  parameter int W  = HALF_W,
  parameter int N  = NKEYS,
  parameter int AW = TAB_AW,
  localparam int IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [W-1:0]      wr_data,
  output logic [N-1:0][W-1:0] keys
);
  logic idx_ok;
  assign idx_ok = (wr_idx < AW'(N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keys <= '0;
    end else if (wr_en && idx_ok) begin
      keys[wr_idx[IW-1:0]] <= wr_data;
    end
  end
endmodule

// File: rtl/fc_tables.sv
module fc_tables
  import fc_pkg::*;
#(
  parameter int W  = HALF_W,
  parameter int NT = NTAB,
  parameter int AW = TAB_AW,
  localparam int DEPTH = 1 << AW
) (
  input  logic                  clk,
  input  logic [NT-1:0]         wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [W-1:0]          wr_data,
  input  logic [NT-1:0][AW-1:0] rd_addr,
  output logic [NT-1:0][W-1:0]  rd_data
);
  for (genvar t = 0; t < NT; t++) begin : g_tab
    logic [W-1:0] mem [DEPTH];
    logic [W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en[t]) mem[wr_addr] <= wr_data;
      rd_q <= mem[rd_addr[t]];
    end

    assign rd_data[t] = rd_q;
  end
endmodule

// File: rtl/fc_core.sv
module fc_core
  import fc_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [BLK_W-1:0]            in_block,
  input  logic                        in_decrypt,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [BLK_W-1:0]            out_block,
  input  logic [NKEYS-1:0][HALF_W-1:0] keys,
  output logic [NTAB-1:0][TAB_AW-1:0] tab_addr,
  input  logic [NTAB-1:0][HALF_W-1:0] tab_rdata,
  output logic                        idle
);
  fc_state_t         st;
  logic [RND_W-1:0]  rnd;
  logic              dec;
  logic [HALF_W-1:0] lh, rh;

  // named internal events
  logic              accept;
  logic              mix_last;
  logic              taken;
  logic [HALF_W-1:0] key_now, lx, f_val, rnew, white_l, white_r;

  assign idle     = (st == ST_IDLE);
  assign in_ready = idle;
  assign out_valid = (st == ST_DONE);
  assign accept   = in_valid && in_ready;
  assign taken    = out_valid && out_ready;
  assign mix_last = (st == ST_MIX) && (rnd == RND_W'(ROUNDS - 1));

  assign key_now = keys[key_index(rnd, dec)];
  assign lx      = lh ^ key_now;

  // byte lanes of the mixed left half address the four tables, MSB first
  for (genvar t = 0; t < NTAB; t++) begin : g_addr
    assign tab_addr[t] = lx[HALF_W-1-TAB_AW*t -: TAB_AW];
  end

  assign f_val   = f_mix(tab_rdata[0], tab_rdata[1], tab_rdata[2], tab_rdata[3]);
  assign rnew    = f_val ^ rh;
  assign white_l = dec ? keys[0] : keys[NKEYS-1];
  assign white_r = dec ? keys[1] : keys[NKEYS-2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      rnd <= '0;
      dec <= 1'b0;
      lh  <= '0;
      rh  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          lh  <= in_block[BLK_W-1:HALF_W];
          rh  <= in_block[HALF_W-1:0];
          dec <= in_decrypt;
          rnd <= '0;
          st  <= ST_LOOK;
        end
        ST_LOOK: begin
          lh <= lx;
          st <= ST_MIX;
        end
        ST_MIX: begin
          if (mix_last) begin
            // last swap cancelled, then whitening
            lh <= lh ^ white_l;
            rh <= rnew ^ white_r;
            st <= ST_DONE;
          end else begin
            lh  <= rnew;
            rh  <= lh;
            rnd <= rnd + 1'b1;
            st  <= ST_LOOK;
          end
        end
        ST_DONE: if (taken) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign out_block = {lh, rh};

  // R4: an accepted block closes the input
  p_accept_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R5: result held until taken
  p_hold_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_block)));

  // R6: final mix step is followed by a valid result
  p_finish_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mix_last |=> out_valid);

  // R5: taking the result reopens the input
  p_reopen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> in_ready);
endmodule

// File: rtl/fc_engine.sv
module fc_engine
  import fc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BLK_W-1:0]  in_block,
  input  logic              in_decrypt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BLK_W-1:0]  out_block,
  input  logic              hw_en,
  input  logic [SEL_W-1:0]  hw_sel,
  input  logic [TAB_AW-1:0] hw_idx,
  input  logic [HALF_W-1:0] hw_data
);
  logic                         idle;
  logic                         wr_open;
  logic                         key_we;
  logic [NTAB-1:0]              tab_we;
  logic [NKEYS-1:0][HALF_W-1:0] keys;
  logic [NTAB-1:0][TAB_AW-1:0]  tab_addr;
  logic [NTAB-1:0][HALF_W-1:0]  tab_rdata;

  assign wr_open = hw_en && idle;
  assign key_we  = wr_open && (hw_sel == '0);
  for (genvar t = 0; t < NTAB; t++) begin : g_we
    assign tab_we[t] = wr_open && (hw_sel == SEL_W'(t + 1));
  end

  fc_subkeys u_keys (
    .clk(clk), .rst_n(rst_n), .wr_en(key_we), .wr_idx(hw_idx),
    .wr_data(hw_data), .keys(keys)
  );

  fc_tables u_tabs (
    .clk(clk), .wr_en(tab_we), .wr_addr(hw_idx), .wr_data(hw_data),
    .rd_addr(tab_addr), .rd_data(tab_rdata)
  );

  fc_core u_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .in_decrypt(in_decrypt), .out_valid(out_valid),
    .out_ready(out_ready), .out_block(out_block), .keys(keys),
    .tab_addr(tab_addr), .tab_rdata(tab_rdata), .idle(idle)
  );

  // R8: key array frozen while the engine is busy
  p_no_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready) |=> $stable(keys));

  // R9: out-of-range targets leave the key array alone
  p_bad_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && (hw_sel > SEL_W'(NTAB))) |=> $stable(keys));
endmodule

// File: tb/fc_engine_bench.sv
module fc_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_block = '0;
  logic        in_decrypt = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_block;
  logic        hw_en = 1'b0;
  logic [2:0]  hw_sel = '0;
  logic [7:0]  hw_idx = '0;
  logic [31:0] hw_data = '0;

  always #2 clk = ~clk;

  fc_engine u_fc_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .in_decrypt(in_decrypt), .out_valid(out_valid),
    .out_ready(out_ready), .out_block(out_block), .hw_en(hw_en),
    .hw_sel(hw_sel), .hw_idx(hw_idx), .hw_data(hw_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference storage, updated by the model
  logic [31:0] mp [18];
  logic [31:0] ms [4][256];

  function automatic logic [31:0] ref_f(input logic [31:0] x);
    logic [31:0] acc;
    acc = ms[0][(x >> 24) & 32'hFF] + ms[1][(x >> 16) & 32'hFF];
    acc = acc ^ ms[2][(x >> 8) & 32'hFF];
    return acc + ms[3][x & 32'hFF];
  endfunction

  function automatic logic [63:0] ref_cipher(input logic [63:0] blk, input bit dec);
    logic [31:0] x, y, t;
    x = blk[63:32];
    y = blk[31:0];
    for (int r = 0; r < 16; r++) begin
      x = x ^ mp[dec ? 17 - r : r];
      y = y ^ ref_f(x);
      t = x; x = y; y = t;
    end
    t = x; x = y; y = t;
    y = y ^ mp[dec ? 1 : 16];
    x = x ^ mp[dec ? 0 : 17];
    return {x, y};
  endfunction

  // cycle model: 0 idle, 1 running, 2 result waiting
  int          m_phase = 0;
  int          m_cnt = 0;
  logic [63:0] m_exp = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
      m_cnt = 0;
      for (int i = 0; i < 18; i++) mp[i] = '0;
    end else begin
      if (hw_en && m_phase == 0) begin
        if (hw_sel == 0 && hw_idx < 18) mp[hw_idx] = hw_data;
        else if (hw_sel >= 1 && hw_sel <= 4) ms[int'(hw_sel) - 1][hw_idx] = hw_data;
      end
      case (m_phase)
        0: if (in_valid) begin
          m_exp = ref_cipher(in_block, in_decrypt);
          m_phase = 1;
          m_cnt = 0;
        end
        1: begin
          m_cnt++;
          if (m_cnt == 32) m_phase = 2;
        end
        default: if (out_ready) m_phase = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 in_ready", 64'(in_ready), 64'(m_phase == 0));
      chk("R6 out_valid", 64'(out_valid), 64'(m_phase == 2));
      if (m_phase == 2) chk("R1 R2 out_block", out_block, m_exp);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic hwrite(input logic [2:0] sel, input logic [7:0] idx, input logic [31:0] d);
    hw_en = 1'b1; hw_sel = sel; hw_idx = idx; hw_data = d;
    tick();
    hw_en = 1'b0;
  endtask

  task automatic run_block(input logic [63:0] blk, input bit dec, input int hold,
                           input bit busy_wr, output logic [63:0] res);
    int n;
    logic [63:0] first;
    in_valid = 1'b1; in_block = blk; in_decrypt = dec;
    tick();
    in_valid = 1'b0;
    chk("R4 busy after accept", 64'(in_ready), 64'(0));
    n = 0;
    if (busy_wr) begin
      hw_en = 1'b1; hw_sel = 3'd0; hw_idx = 8'd0; hw_data = ~mp[0];
      tick(); n++;
      hw_sel = 3'd1; hw_idx = 8'd0; hw_data = ~ms[0][0];
      tick(); n++;
      hw_en = 1'b0;
    end
    while (!out_valid && n < 1000) begin
      tick(); n++;
    end
    chk("R6 latency", 64'(n), 64'd32);
    first = out_block;
    repeat (hold) tick();
    chk("R5 held output", out_block, first);
    chk("R5 still valid", 64'(out_valid), 64'd1);
    res = out_block;
    out_ready = 1'b1;
    tick();
    out_ready = 1'b0;
    chk("R5 ready after take", 64'(in_ready), 64'd1);
  endtask

  initial begin
    logic [31:0] seed;
    logic [63:0] res, back, exp;
    logic [63:0] pats [4];
    pats[0] = 64'h0;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hAAAA_AAAA_5555_5555;
    pats[3] = 64'h0123_4567_89AB_CDEF;

    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk("R10 in_ready after reset", 64'(in_ready), 64'd1);
    chk("R10 out_valid after reset", 64'(out_valid), 64'd0);
    // R10: zero keys, zero tables -> all-zero block maps to zero
    for (int t = 1; t <= 4; t++)
      for (int i = 0; i < 256; i++) hwrite(3'(t), 8'(i), 32'h0);
    run_block(64'h0, 1'b0, 0, 1'b0, res);
    chk("R10 zero keys", res, 64'h0);

    // R7: load keys and tables
    seed = 32'h1234_5678;
    for (int i = 0; i < 18; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      hwrite(3'd0, 8'(i), seed);
    end
    for (int t = 1; t <= 4; t++)
      for (int i = 0; i < 256; i++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        hwrite(3'(t), 8'(i), seed ^ 32'(t * 32'h0101_0101));
      end

    foreach (pats[p]) begin
      exp = ref_cipher(pats[p], 1'b0);
      run_block(pats[p], 1'b0, p, 1'b0, res);
      chk("R1 R2 encrypt pattern", res, exp);
      run_block(res, 1'b1, 1, 1'b0, back);
      chk("R3 round trip", back, pats[p]);
    end

    // R8: writes during a run are refused
    exp = ref_cipher(pats[3], 1'b0);
    run_block(pats[3], 1'b0, 0, 1'b1, res);
    chk("R8 run with busy writes", res, exp);
    run_block(pats[3], 1'b0, 0, 1'b0, res);
    chk("R8 storage unchanged", res, exp);

    // R9: invalid targets ignored
    hwrite(3'd5, 8'd0, 32'hCAFE_F00D);
    hwrite(3'd7, 8'd3, 32'h0BAD_0BAD);
    hwrite(3'd0, 8'd18, 32'h1111_2222);
    hwrite(3'd0, 8'd200, 32'h3333_4444);
    run_block(pats[2], 1'b0, 0, 1'b0, res);
    chk("R9 invalid writes ignored", res, exp === res ? res : ref_cipher(pats[2], 1'b0));
    chk("R9 result vs reference", res, ref_cipher(pats[2], 1'b0));

    // R7: one table entry and the last key changed between runs
    exp = ref_cipher(pats[3], 1'b0);
    hwrite(3'd4, 8'h5A, 32'hDEAD_BEEF);
    hwrite(3'd0, 8'd17, 32'h8000_0001);
    res = ref_cipher(pats[3], 1'b0);
    chk("R7 reference moved", 64'(res != exp), 64'd1);
    run_block(pats[3], 1'b0, 0, 1'b0, back);
    chk("R7 new storage used", back, res);
    run_block(back, 1'b1, 0, 1'b0, res);
    chk("R3 round trip after update", res, pats[3]);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL R6 watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule